// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two binary32 operands (1 sign bit, 8-bit exponent biased by 127, 23 stored fraction bits with an implied leading one) and returns a binary32 result with two range flags. An operation is launched by a one-cycle `start` pulse. The block then runs a short sequence of steps and raises `done` for one cycle when the result is ready.

Inside, the leading one of each operand is restored. The operand with the smaller exponent is shifted right into a field that carries three extra low bits (guard, round, sticky). The two significands are combined as signed two's-complement numbers, so subtraction uses the same adder. The magnitude of the sum is then normalized. A carry out is fixed by a single right shift. Cancellation is fixed by one left shift per cycle, each of which lowers the exponent by one. The result is rounded to nearest-even, renormalized if the rounding carried out, and packed again without the leading one. An operand whose exponent field is zero is read as zero, whatever its fraction.

Top module: `fp32_addsub`

## Requirements
- R1: `opa` and `opb` are binary32 values with the sign in bit 31, the exponent in bits 30:23 (bias 127) and the fraction in bits 22:0. `result` uses the same encoding and equals `opa + opb` when `sub` is 0 and `opa - opb` when `sub` is 1.
- R2: A `start` seen while idle is accepted. `busy` is 1 from the cycle after acceptance until `done`. `done` is high for exactly one cycle. `result`, `ovf` and `unf` hold their values until the next accepted operation completes.
- R3: A `start` that arrives while `busy` is 1 is ignored: the operation in progress completes with its own operands.
- R4: Rounding is to nearest, with ties to an even fraction (fraction bit 0 equal to 0), and is based on the bits that fall below the 24-bit significand.
- R5: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one.
- R6: Massive cancellation is normalized exactly. For example, 0x3F000000 minus 0x3EE00000 gives 0x3D800000.
- R7: A sum that is exactly zero is encoded as 0x00000000 (positive zero) with both flags at 0.
- R8: An operand whose exponent field is 0 is treated as zero, regardless of its fraction bits.
- R9: If the rounded biased exponent exceeds 254, `ovf` is 1, `unf` is 0 and `result` is the sign followed by 0x7F800000 in bits 30:0.
- R10: If the rounded biased exponent falls below 1, `unf` is 1, `ovf` is 0 and `result` is 0x00000000.
- R11: Every accepted operation raises `done` within 32 cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| sub | input | 1 | 1 selects opa - opb, 0 selects opa + opb |
| opa | input | 32 | First binary32 operand |
| opb | input | 32 | Second binary32 operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 32 | Rounded binary32 result |
| ovf | output | 1 | Result exponent above the normal range |
| unf | output | 1 | Result exponent below the normal range |

## Verification
The bench aims at the cases where the guard, round and sticky bits decide the answer. A tie that must stay even catches a design that always rounds up, since it would land one ulp high. A tie on an odd fraction catches truncation, which would land one ulp low. A round-up that carries out catches a missing renormalization step, which would leave a wrong exponent. Operands with equal or adjacent exponents and nearly equal fractions force long left shifts, where a bad shift count or a lost sticky bit would show up as a wrong exponent or a wrong last bit. The bench also covers exact cancellation, which must give positive zero; zero-exponent operands, which must act as zero; both range limits, which must set the matching flag and pattern; and a start issued while busy, which must not corrupt the running operation.

// File: rtl/fp32_addsub_pkg.sv
package fp32_addsub_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;          // with restored leading one
    localparam int XTRA_W = 3;                   // guard, round, sticky
    localparam int EXT_W  = SIG_W + XTRA_W;      // aligned significand
    localparam int MAG_W  = EXT_W + 1;           // plus carry position
    localparam int SUM_W  = MAG_W + 1;           // plus two's-complement sign
    localparam int EW     = EXP_W + 2;           // signed working exponent
    localparam int LAT_MAX = SIG_W + 8;          // bound on busy cycles

    typedef struct packed {
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic                 sgn;
        logic signed [EW-1:0] exp;
        logic [MAG_W-1:0]     mag;
    } work_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_NORM  = 2'd2,
        ST_ROUND = 2'd3
    } st_e;

    // significand with the implied one; a zero exponent field reads as zero
    function automatic logic [SIG_W-1:0] full_sig(input fp_t x);
        if (x.exp == '0) return '0;
        return {1'b1, x.frac};
    endfunction

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
    import fp32_addsub_pkg::*;
(
    input  fp_t   a,
    input  fp_t   b,
    input  logic  sub,
    output work_t w
);
    logic             b_sgn;
    logic             a_big;
    logic [SIG_W-1:0] big_sig, sml_sig;
    logic             big_sgn, sml_sgn;
    logic [EXP_W-1:0] big_exp, diff;
    logic [EXT_W-1:0] ext_big, ext_sml, shifted, lowmask, aligned;
    logic             lost;
    logic [SUM_W-1:0] term_big, term_sml, sum;

    always_comb begin
        b_sgn   = b.sgn ^ sub;
        a_big   = (a.exp >= b.exp);
        big_sig = a_big ? full_sig(a) : full_sig(b);
        sml_sig = a_big ? full_sig(b) : full_sig(a);
        big_sgn = a_big ? a.sgn : b_sgn;
        sml_sgn = a_big ? b_sgn : a.sgn;
        big_exp = a_big ? a.exp : b.exp;
        diff    = a_big ? (a.exp - b.exp) : (b.exp - a.exp);

        ext_big = {big_sig, {XTRA_W{1'b0}}};
        ext_sml = {sml_sig, {XTRA_W{1'b0}}};

        if (diff >= EXP_W'(EXT_W)) begin
            shifted = '0;
            lost    = |ext_sml;
            lowmask = '1;
        end else begin
            shifted = ext_sml >> diff;
            lowmask = ({{(EXT_W-1){1'b0}}, 1'b1} << diff) - {{(EXT_W-1){1'b0}}, 1'b1};
            lost    = |(ext_sml & lowmask);
        end
        aligned = {shifted[EXT_W-1:1], shifted[0] | lost};

        term_big = big_sgn ? -{2'b00, ext_big} : {2'b00, ext_big};
        term_sml = sml_sgn ? -{2'b00, aligned} : {2'b00, aligned};
        sum      = term_big + term_sml;

        w.sgn = sum[SUM_W-1];
        w.exp = {2'b00, big_exp};
        w.mag = MAG_W'(sum[SUM_W-1] ? -sum : sum);
    end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
    import fp32_addsub_pkg::*;
(
    input  work_t w,
    output work_t nxt,
    output logic  fin
);
    always_comb begin
        nxt = w;
        fin = 1'b1;
        if (w.mag[MAG_W-1]) begin
            // carry out of the add: one right step, keep lost bit sticky
            nxt.mag = {1'b0, w.mag[MAG_W-1:2], w.mag[1] | w.mag[0]};
            nxt.exp = w.exp + EW'(1);
        end else if (w.mag != '0 && !w.mag[EXT_W-1]) begin
            // cancellation: one left step per cycle
            nxt.mag = {w.mag[MAG_W-2:0], 1'b0};
            nxt.exp = w.exp - EW'(1);
            fin     = 1'b0;
        end
    end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fp32_addsub_pkg::*;
(
    input  work_t w,
    output fp_t   res,
    output logic  ovf,
    output logic  unf
);
    localparam logic signed [EW-1:0] E_TOP = EW'((1 << EXP_W) - 2);
    localparam logic signed [EW-1:0] E_BOT = EW'(1);

    logic [SIG_W-1:0]     keep;
    logic                 g, r, s, inc;
    logic [SIG_W:0]       rnd;
    logic signed [EW-1:0] e1;
    logic [FRAC_W-1:0]    frac;

    always_comb begin
        keep = w.mag[EXT_W-1:XTRA_W];
        g    = w.mag[2];
        r    = w.mag[1];
        s    = w.mag[0];
        inc  = g & (r | s | keep[0]);
        rnd  = {1'b0, keep} + {{SIG_W{1'b0}}, inc};
        e1   = rnd[SIG_W] ? (w.exp + EW'(1)) : w.exp;
        frac = rnd[SIG_W] ? rnd[SIG_W-1:1] : rnd[FRAC_W-1:0];

        res = '0;
        ovf = 1'b0;
        unf = 1'b0;
        if (w.mag == '0) begin
            res = '0;
        end else if (e1 > E_TOP) begin
            ovf      = 1'b1;
            res.sgn  = w.sgn;
            res.exp  = '1;
        end else if (e1 < E_BOT) begin
            unf = 1'b1;
        end else begin
            res.sgn  = w.sgn;
            res.exp  = e1[EXP_W-1:0];
            res.frac = frac;
        end
    end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
    import fp32_addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    localparam int CNT_W = $clog2(LAT_MAX + 1);

    st_e   state;
    fp_t   a_q, b_q;
    logic  sub_q;
    work_t wk, align_w, norm_w;
    logic  norm_fin;
    fp_t   rnd_res;
    logic  rnd_ovf, rnd_unf;

    fpadd_align u_align (.a(a_q), .b(b_q), .sub(sub_q), .w(align_w));
    fpadd_norm  u_norm  (.w(wk), .nxt(norm_w), .fin(norm_fin));
    fpadd_round u_round (.w(wk), .res(rnd_res), .ovf(rnd_ovf), .unf(rnd_unf));

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            a_q    <= '0;
            b_q    <= '0;
            sub_q  <= 1'b0;
            wk     <= '0;
            result <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    a_q   <= opa;
                    b_q   <= opb;
                    sub_q <= sub;
                    state <= ST_ALIGN;
                end
                ST_ALIGN: begin
                    wk    <= align_w;
                    state <= ST_NORM;
                end
                ST_NORM: begin
                    wk <= norm_w;
                    if (norm_fin) state <= ST_ROUND;
                end
                ST_ROUND: begin
                    result <= rnd_res;
                    ovf    <= rnd_ovf;
                    unf    <= rnd_unf;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // checker-side latency counter
    logic [CNT_W-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len <= '0;
        else if (busy_len != '1) busy_len <= busy_len + CNT_W'(1);
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(ovf) && $stable(unf)));
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(sub_q)));
    p_round_in_norm_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUND) |-> (!wk.mag[MAG_W-1] && (wk.mag[EXT_W-1] || wk.mag == '0)));
    p_ovf_pattern_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (!unf && result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    p_unf_pattern_r10: assert property (@(posedge clk) disable iff (rst)
        unf |-> (!ovf && result == '0));
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < CNT_W'(LAT_MAX)));
endmodule

// File: tb/fp32_addsub_bench.sv
module fp32_addsub_bench;
    localparam int BW = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sub = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy, done, ovf, unf;
    logic [31:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fp32_addsub u_fp32_addsub (
        .clk(clk), .rst(rst), .start(start), .sub(sub), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .result(result), .ovf(ovf), .unf(unf));

    task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // exact wide-integer model: returns {ovf, unf, result}
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic [BW-1:0] ma, mb, m, tmp, rem, half;
        logic [24:0]   mant;
        int ea, eb, emin, p, sh, e;
        logic sa, sb, sr;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        emin = (ea < eb) ? ea : eb;
        ma = (ea == 0) ? '0 : BW'({1'b1, a[22:0]});
        mb = (eb == 0) ? '0 : BW'({1'b1, b[22:0]});
        ma = ma << (ea - emin);
        mb = mb << (eb - emin);
        sa = a[31];
        sb = b[31] ^ s;
        if (sa == sb) begin m = ma + mb; sr = sa; end
        else if (ma >= mb) begin m = ma - mb; sr = sa; end
        else begin m = mb - ma; sr = sb; end
        if (m == '0) return 34'd0;
        p = 0;
        for (int i = 0; i < BW; i++) if (m[i]) p = i;
        e = emin + p - 23;
        if (p > 23) begin
            sh   = p - 23;
            tmp  = m >> sh;
            mant = tmp[24:0];
            rem  = m & ((BW'(1) << sh) - BW'(1));
            half = BW'(1) << (sh - 1);
            if (rem > half || (rem == half && mant[0])) mant = mant + 25'd1;
            if (mant[24]) begin mant = mant >> 1; e = e + 1; end
        end else begin
            tmp  = m << (23 - p);
            mant = tmp[24:0];
        end
        if (e >= 255) return {2'b10, sr, 8'hFF, 23'd0};
        if (e <= 0)   return {2'b01, 32'd0};
        return {2'b00, sr, e[7:0], mant[22:0]};
    endfunction

    task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic s);
        @(negedge clk);
        opa = a; opb = b; sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 64; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s, input string req);
        bit got;
        logic [33:0] exp;
        exp = model(a, b, s);
        launch(a, b, s);
        wait_done(got);
        check(got, {req, " R11 done in time"}, {33'd0, got}, 34'd1);
        check({ovf, unf, result} == exp, req, {ovf, unf, result}, exp);
    endtask

    task automatic run_fixed(input logic [31:0] a, input logic [31:0] b, input logic s,
                             input logic [33:0] exp, input string req);
        run_op(a, b, s, req);
        check({ovf, unf, result} == exp, {req, " fixed"}, {ovf, unf, result}, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        bit got;
        logic [33:0] exp;
        void'($urandom(32'd24681357));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R2
        check(!busy && !done && result == 0 && !ovf && !unf, "R2 reset",
              {ovf, unf, result}, 34'd0);

        run_fixed(32'h3F000000, 32'h3EE00000, 1'b1, {2'b00, 32'h3D800000}, "R6 cancel");
        run_fixed(32'hBF000000, 32'hBE800000, 1'b0, {2'b00, 32'hBF400000}, "R1 neg add");
        run_fixed(32'hC0000000, 32'h40000000, 1'b1, {2'b00, 32'hC0800000}, "R1 sub");
        run_fixed(32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000}, "R4 tie even");
        run_fixed(32'h3F800001, 32'h33800000, 1'b0, {2'b00, 32'h3F800002}, "R4 tie odd");
        run_fixed(32'h3FFFFFFF, 32'h33800000, 1'b0, {2'b00, 32'h40000000}, "R5 round carry");
        run_fixed(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000}, "R9 overflow");
        run_fixed(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b10, 32'hFF800000}, "R9 neg overflow");
        run_fixed(32'h00800001, 32'h00800000, 1'b1, {2'b01, 32'h00000000}, "R10 underflow");
        run_fixed(32'h40490FDB, 32'h40490FDB, 1'b1, {2'b00, 32'h00000000}, "R7 exact zero");
        run_fixed(32'hC0490FDB, 32'h40490FDB, 1'b0, {2'b00, 32'h00000000}, "R7 neg exact zero");
        run_fixed(32'h00000001, 32'h3F800000, 1'b0, {2'b00, 32'h3F800000}, "R8 denormal as zero");
        run_fixed(32'h807FFFFF, 32'h00400000, 1'b1, {2'b00, 32'h00000000}, "R8 two denormals");

        // R2: outputs hold while idle with no start
        hold = result;
        repeat (5) @(negedge clk);
        check(result == hold && !busy && !done, "R2 hold", {2'b00, result}, {2'b00, hold});

        // R3: start while busy is ignored
        exp = model(32'h3FC00000, 32'h3F000000, 1'b0);
        launch(32'h3FC00000, 32'h3F000000, 1'b0);
        check(busy, "R2 busy after accept", {33'd0, busy}, 34'd1);
        opa = 32'h42000000; opb = 32'h41000000; sub = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        check(got && {ovf, unf, result} == exp, "R3 start ignored", {ovf, unf, result}, exp);
        @(negedge clk);
        check(!done && !busy, "R2 done one cycle", {32'd0, done, busy}, 34'd0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int ea, eb, mode;
            logic [31:0] a, b;
            ea = $urandom_range(254, 1);
            mode = $urandom_range(3, 0);
            case (mode)
                0: eb = $urandom_range(254, 1);
                1: begin
                    eb = ea + $urandom_range(4, 0) - 2;
                    if (eb < 1) eb = 1;
                    if (eb > 254) eb = 254;
                end
                2: eb = ea;
                default: eb = 0;
            endcase
            a = {$urandom_range(1, 0) == 1, ea[7:0], 23'($urandom)};
            if (mode == 2) b = {$urandom_range(1, 0) == 1, eb[7:0], a[22:0] ^ 23'($urandom_range(63, 0))};
            else           b = {$urandom_range(1, 0) == 1, eb[7:0], 23'($urandom)};
            if ($urandom_range(1, 0) == 1) run_op(b, a, $urandom_range(1, 0) == 1, "R1 R4 random");
            else                           run_op(a, b, $urandom_range(1, 0) == 1, "R1 R6 random");
        end

        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule